// File: doc/BRIEF.md
# Fall-Through Marker FIFO

This block is a sixteen-word first-in first-out buffer for four-bit words. It has no read or write pointers. It is a chain of stages, and each stage holds one word and one occupancy marker. A stage that is vacant takes the word from its occupied predecessor. As a result, written words fall toward the output end one stage per clock, and vacancies bubble back toward the input end. Earlier words therefore always sit nearer the output than later ones.

The design is synchronous to a single clock. The shift-in and shift-out strobes are clock-enable pulses that are sampled at the rising edge. The input-ready flag shows that the first stage is vacant. The output-ready flag shows that the last stage holds a word. The last stage's word drives a data output that an output-enable input can float. Popping does not depend on that enable.

Top module: `ripple_fifo`

## Requirements
- R1: While rstN is low at a rising clock edge, every marker clears, so that afterwards inReady is 1 and outReady is 0. A reset in the middle of operation discards all stored words.
- R2: A shiftIn pulse sampled while inReady is 1 stores dataIn in the first stage, and inReady is 0 in the following cycle.
- R3: A shiftIn pulse sampled while inReady is 0 is ignored, and no extra word ever reaches the output.
- R4: Words leave in the order they were accepted, under any interleaving of shift-in and shift-out, including both in the same cycle.
- R5: A word accepted into an empty buffer makes outReady rise exactly 16 rising edges after the edge that accepted it, counting that edge.
- R6: At most 16 words are held. After 16 accepted writes with no reads, inReady stays 0 and outReady stays 1.
- R7: A shiftOut pulse sampled while outReady is 1 removes the output word, and outReady is 0 in the following cycle.
- R8: A shiftOut pulse while outReady is 0 is ignored, and a later word still arrives intact.
- R9: dataOut is high impedance (4'bzzzz) while outEn is 0 and shows the last stage's word while outEn is 1. shiftOut removes a word regardless of outEn.
- R10: A marker becomes set only when its predecessor was set in the previous cycle, so each word advances at most one stage per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Reset, active low, acting at the clock edge |
| shiftIn | input | 1 | Write strobe, one-cycle enable |
| dataIn | input | 4 | Word to write |
| inReady | output | 1 | First stage vacant, so a write can be accepted |
| shiftOut | input | 1 | Read strobe, one-cycle enable |
| outEn | input | 1 | Output enable for dataOut |
| dataOut | output | 4 | Last stage's word, or high impedance when outEn is 0 |
| outReady | output | 1 | Last stage holds a valid word |

## Verification
A write at the input end and a pop at the output end can land on the same clock edge, while words are rippling through the middle stages. The bench drives both strobes from an LFSR across sixteen pairs of write and read rates. It often raises each strobe while the matching ready flag is low. A strobe counts as accepted only when its ready flag was high at the edge. Every popped word is compared against a bench-side queue of accepted words, and the queue's depth is checked never to exceed sixteen.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;
  parameter int unsigned STAGES = 16;
  parameter int unsigned WORD_W = 4;
  localparam int unsigned CNT_W = $clog2(STAGES + 1);

  // Strobes from the marker chain to the word registers.
  typedef struct packed {
    logic              load;   // capture dataIn into stage 0
    logic [STAGES-1:1] move;   // stage i takes the word of stage i-1
  } stageCtl_t;
endpackage

// File: rtl/ripple_fifo_ctrl.sv
module ripple_fifo_ctrl
  import ripple_fifo_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      shiftIn,
  input  logic      shiftOut,
  output stageCtl_t ctl,
  output logic      inReady,
  output logic      outReady
);
  logic [STAGES-1:0] mark;
  logic [STAGES-1:0] markNext;
  logic [STAGES-1:0] leave;

  assign ctl.load = shiftIn && !mark[0];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i > 0) begin : g_move
        // A vacant stage pulls from an occupied predecessor.
        assign ctl.move[i] = mark[i-1] && !mark[i];
      end
      if (i < STAGES - 1) begin : g_leaveMid
        assign leave[i] = ctl.move[i+1];
      end else begin : g_leaveLast
        assign leave[i] = shiftOut && mark[i];
      end
      if (i == 0) begin : g_first
        assign markNext[i] = (mark[i] && !leave[i]) || ctl.load;
      end else begin : g_rest
        assign markNext[i] = (mark[i] && !leave[i]) || ctl.move[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) mark <= '0;
    else       mark <= markNext;
  end

  assign inReady  = !mark[0];
  assign outReady = mark[STAGES-1];

  generate
    for (i = 1; i < STAGES; i++) begin : g_chk
      assert_one_step_R10: assert property (@(posedge clk) disable iff (!rstN)
        $rose(mark[i]) |-> $past(mark[i-1]));
    end
  endgenerate

  assert_load_fills_R2: assert property (@(posedge clk) disable iff (!rstN)
    (shiftIn && inReady) |=> !inReady);

  assert_pop_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (shiftOut && outReady) |=> !outReady);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(mark) <= $past($countones(mark)) + 1);
endmodule

// File: rtl/ripple_fifo_data.sv
module ripple_fifo_data
  import ripple_fifo_pkg::*;
(
  input  logic              clk,
  input  stageCtl_t         ctl,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] lastWord
);
  logic [WORD_W-1:0] word [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_word
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (ctl.load) word[i] <= dataIn;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (ctl.move[i]) word[i] <= word[i-1];
        end
      end
    end
  endgenerate

  assign lastWord = word[STAGES-1];
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
  import ripple_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftIn,
  input  logic [WORD_W-1:0] dataIn,
  output logic              inReady,
  input  logic              shiftOut,
  input  logic              outEn,
  output logic [WORD_W-1:0] dataOut,
  output logic              outReady
);
  stageCtl_t         ctl;
  logic [WORD_W-1:0] lastWord;

  ripple_fifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .ctl(ctl), .inReady(inReady), .outReady(outReady)
  );

  ripple_fifo_data u_data (
    .clk(clk), .ctl(ctl), .dataIn(dataIn), .lastWord(lastWord)
  );

  assign dataOut = outEn ? lastWord : 'z;
endmodule

// File: tb/ripple_fifo_tb_top.sv
`timescale 1ns/1ps
module ripple_fifo_tb_top;
  logic       clk = 0;
  logic       rstN = 0;
  logic       shiftIn = 0;
  logic [3:0] dataIn = 0;
  logic       shiftOut = 0;
  logic       outEn = 1;
  wire  [3:0] dataOut;
  wire        inReady;
  wire        outReady;

  int checks = 0;
  int failures = 0;
  logic [3:0] mq [0:63];
  int head = 0;
  int tail = 0;
  int cnt = 0;
  logic [3:0] nextVal = 4'h1;
  logic [15:0] lfsr = 16'hACE1;

  ripple_fifo dut_i (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .dataIn(dataIn),
    .inReady(inReady), .shiftOut(shiftOut), .outEn(outEn),
    .dataOut(dataOut), .outReady(outReady)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic modelPush(input logic [3:0] v);
    mq[tail] = v; tail = (tail + 1) % 64; cnt++;
  endtask

  task automatic pushWord(input logic [3:0] v);
    int n = 0;
    while (!inReady && n < 100) begin step(); n++; end
    shiftIn = 1; dataIn = v;
    step();
    shiftIn = 0;
    modelPush(v);
  endtask

  // Returns 1 if a word was popped and checked, 0 if none arrived in time.
  task automatic popCheck(input string req, output bit got);
    int n = 0;
    got = 0;
    while (!outReady && n < 40) begin step(); n++; end
    if (outReady) begin
      got = 1;
      check(cnt > 0 && dataOut === mq[head], req, int'(dataOut), int'(mq[head]));
      if (cnt > 0) begin head = (head + 1) % 64; cnt--; end
      shiftOut = 1;
      step();
      shiftOut = 0;
    end
  endtask

  task automatic drainAll(input string req);
    bit got = 1;
    while (got) popCheck(req, got);
    check(cnt == 0, req, cnt, 0);
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    int lat;
    bit got;
    repeat (3) step();
    rstN = 1;
    step();
    // R1 reset state
    check(inReady === 1'b1, "R1", int'(inReady), 1);
    check(outReady === 1'b0, "R1", int'(outReady), 0);

    // R5 latency and R2 load
    shiftIn = 1; dataIn = 4'hA;
    @(posedge clk); lat = 1;
    @(negedge clk); shiftIn = 0; modelPush(4'hA);
    check(inReady === 1'b0, "R2", int'(inReady), 0);
    while (!outReady && lat < 40) begin @(posedge clk); lat++; @(negedge clk); end
    check(lat == 16, "R5", lat, 16);
    check(dataOut === 4'hA, "R4", int'(dataOut), 10);

    // R9 tristate and pop independent of enable
    outEn = 0; #0.1;
    check(dataOut === 4'bzzzz, "R9", int'(dataOut), 0);
    shiftOut = 1; step(); shiftOut = 0;
    head = (head + 1) % 64; cnt--;
    check(outReady === 1'b0, "R9", int'(outReady), 0);
    outEn = 1;
    repeat (20) step();
    check(outReady === 1'b0, "R7", int'(outReady), 0);

    // R8 pop on empty ignored
    shiftOut = 1; repeat (3) step(); shiftOut = 0;
    check(outReady === 1'b0, "R8", int'(outReady), 0);
    pushWord(4'h9);
    popCheck("R8", got);
    check(got == 1, "R8", int'(got), 1);

    // R6 capacity and R3 ignored write when full
    for (int k = 0; k < 16; k++) pushWord(4'(k + 3));
    repeat (40) step();
    check(inReady === 1'b0, "R6", int'(inReady), 0);
    check(outReady === 1'b1, "R6", int'(outReady), 1);
    shiftIn = 1; dataIn = 4'hF; step(); shiftIn = 0;
    repeat (5) step();
    check(inReady === 1'b0, "R3", int'(inReady), 0);
    drainAll("R3");

    // R7 pop then next word follows
    pushWord(4'h1); pushWord(4'h2);
    popCheck("R7", got);
    check(outReady === 1'b0, "R7", int'(outReady), 0);
    popCheck("R7", got);
    check(got == 1, "R7", int'(got), 1);

    // R1 reset mid-operation
    pushWord(4'h4); pushWord(4'h5); pushWord(4'h6);
    repeat (4) step();
    rstN = 0; step(); rstN = 1;
    head = 0; tail = 0; cnt = 0;
    check(inReady === 1'b1, "R1", int'(inReady), 1);
    repeat (30) step();
    check(outReady === 1'b0, "R1", int'(outReady), 0);

    // R4 sweep of write/read rates with concurrent strobes
    for (int pi = 0; pi < 4; pi++) begin
      for (int po = 0; po < 4; po++) begin
        for (int c = 0; c < 300; c++) begin
          bit wi, wo, acc, pop;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          wi = (lfsr[1:0] <= 2'(pi));
          wo = (lfsr[5:4] <= 2'(po));
          acc = wi && inReady;
          pop = wo && outReady;
          if (pop) begin
            check(cnt > 0 && dataOut === mq[head], "R4", int'(dataOut), int'(mq[head]));
            if (cnt > 0) begin head = (head + 1) % 64; cnt--; end
          end
          shiftIn = wi; dataIn = nextVal; shiftOut = wo;
          step();
          if (acc) begin
            modelPush(nextVal);
            nextVal = nextVal + 4'h7;
            if (cnt > 16) check(0, "R6", cnt, 16);
          end
        end
        shiftIn = 0; shiftOut = 0;
        drainAll("R4");
      end
    end
    finish();
  end
endmodule